// File: doc/BRIEF.md
# Reciprocal Square Root Estimator

This unit takes one IEEE-754 binary operand and returns an estimate of 1/sqrt(x). The estimate is good to seven bits. A format input selects single precision (binary32) or double precision (binary64). Each result carries two exception flags: invalid operation and divide-by-zero.

The significand of the estimate comes from a 128-entry table of 7-bit values. The table is indexed by the parity of the operand's normalized exponent and the six leading bits of its normalized fraction. The unit normalizes subnormal operands itself. It treats zeros, infinities, NaNs and negative operands as special cases.

One register stage sits between the operand and the result. A valid strobe travels with the data, so a caller can issue one operand per clock. A refinement step, such as Newton iteration, is expected to follow in the surrounding datapath.

Top module: `rsqrt_est`

## Requirements
- R1: `outValid` goes high exactly one clock after a cycle with `inValid` high and is low one clock after a cycle with `inValid` low. While `rstN` is low, all outputs are zero.
- R2: With `inDouble` = 0, the operand is `inOperand[31:0]` (bias 127, 23-bit fraction, exponent in bits 30:23). `inOperand[63:32]` is ignored and `outResult[63:32]` is zero. With `inDouble` = 1, the whole word is used (bias 1023, 52-bit fraction, exponent in bits 62:52).
- R3: For a positive finite nonzero operand, the table index is {p, f[5:0]}. Here p is bit 0 of the normalized biased exponent e, and f holds the six leading bits of the normalized fraction. The table entry is y-128, where y is the largest integer with y*y*k*(2*f+129) <= 2^23, and k is 2 when p = 0 and 1 when p = 1. The entry fills the top seven fraction bits of the result. The remaining fraction bits are zero.
- R4: For a positive normal operand, the result sign is 0 and the result biased exponent is floor((3*bias - 1 - e)/2).
- R5: A positive subnormal operand is normalized first. With z leading zero bits in its fraction, e = -z, and the fraction is shifted left by z+1 bits before indexing. The result exponent then follows R4 with this e.
- R6: A zero of either sign returns an infinity of the same sign and raises divide-by-zero only.
- R7: A negative nonzero operand, including negative infinity, returns the canonical quiet NaN and raises invalid only. The canonical quiet NaN is 0x7FC00000 in single and 0x7FF8000000000000 in double.
- R8: A NaN operand returns the canonical quiet NaN. Invalid is raised only when the fraction MSB is 0 (signaling NaN).
- R9: Positive infinity returns +0 with no flag.
- R10: In a clock edge with `inValid` low, `outResult`, `outInvalid` and `outDivZero` keep their previous values.
- R11: A positive finite nonzero operand raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| inDouble | input | 1 | 1 selects double precision, 0 single |
| inOperand | input | 64 | Operand bits |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| outResult | output | 64 | Estimate, or special result |
| outInvalid | output | 1 | Invalid-operation flag |
| outDivZero | output | 1 | Divide-by-zero flag |

## Verification
A wrong table entry or a wrong index shows in the top seven fraction bits of the very next result. A wrong leading-zero count or a wrong parity shows as a wrong exponent or fraction on the first subnormal operand. A flipped exponent formula shows on any normal operand. Every such fault is visible one clock after the operand is issued, because the unit keeps no state beyond its output register.

Random operands are biased toward zero and all-ones exponent fields, so the special-case routing is exercised often. Idle cycles between operands expose a register that loads when it should hold.

// File: rtl/rsqrt_pkg.sv
package rsqrt_pkg;
  localparam int WORD_W    = 64;
  localparam int SP_FRAC_W = 23;
  localparam int SP_EXP_W  = 8;
  localparam int DP_FRAC_W = 52;
  localparam int DP_EXP_W  = 11;
  localparam int SP_BIAS   = 127;
  localparam int DP_BIAS   = 1023;
  localparam int ROM_AW    = 7;
  localparam int ROM_DW    = 7;
  localparam int LZ_W      = $clog2(DP_FRAC_W);
  localparam int EXP_CALC_W = DP_EXP_W + 3;

  typedef struct packed {
    logic capture;
    logic fmtDouble;
  } strobes_t;
endpackage

// File: rtl/rsqrt_rom.sv
module rsqrt_rom #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 7
) (
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DEPTH / 2;
  localparam int YMIN  = 1 << DATA_W;
  localparam int LIMIT = 1 << 23;

  // Entry = floor(256*sqrt(128/(k*(2f+129)))) - 128, computed exactly with integers.
  function automatic logic [DATA_W-1:0] entryOf(input int idx);
    int k, d, y;
    k = (idx >= HALF) ? 1 : 2;
    d = k * (2 * (idx % HALF) + 129);
    y = YMIN;
    for (int t = YMIN; t < 2 * YMIN; t++)
      if (t * t * d <= LIMIT) y = t;
    return DATA_W'(y - YMIN);
  endfunction

  logic [DATA_W-1:0] table_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign table_q[g] = entryOf(g);
  end

  assign rdData = table_q[rdAddr];
endmodule

// File: rtl/rsqrt_ctrl.sv
module rsqrt_ctrl
  import rsqrt_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     inDouble,
  output strobes_t strobes,
  output logic     outValid
);
  always_comb begin
    strobes.capture   = inValid;
    strobes.fmtDouble = inDouble;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/rsqrt_dp.sv
module rsqrt_dp
  import rsqrt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [WORD_W-1:0] operand,
  output logic [WORD_W-1:0] result,
  output logic              flagInvalid,
  output logic              flagDivZero
);
  localparam int ALIGN = DP_FRAC_W - SP_FRAC_W;
  localparam logic [WORD_W-1:0] SP_QNAN = 64'h0000_0000_7FC0_0000;
  localparam logic [WORD_W-1:0] DP_QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [EXP_CALC_W-1:0] SP_BASE = EXP_CALC_W'(3 * SP_BIAS - 1);
  localparam logic [EXP_CALC_W-1:0] DP_BASE = EXP_CALC_W'(3 * DP_BIAS - 1);

  logic                  dbl, sign;
  logic [DP_EXP_W-1:0]   expField, expMax;
  logic [DP_FRAC_W-1:0]  frac, normFrac;
  logic                  expZero, expOnes, fracZero;
  logic                  isZero, isSub, isInf, isNan;
  logic [LZ_W-1:0]       lz;
  logic [EXP_CALC_W-1:0] expNum, expRes;
  logic [ROM_AW-1:0]     romIdx;
  logic [ROM_DW-1:0]     romVal;
  logic [WORD_W-1:0]     nextRes;
  logic                  nextInv, nextDz;

  always_comb begin
    dbl      = strobes.fmtDouble;
    sign     = dbl ? operand[WORD_W-1] : operand[31];
    expField = dbl ? operand[DP_FRAC_W +: DP_EXP_W]
                   : DP_EXP_W'(operand[SP_FRAC_W +: SP_EXP_W]);
    frac     = dbl ? operand[DP_FRAC_W-1:0]
                   : {operand[SP_FRAC_W-1:0], {ALIGN{1'b0}}};
    expMax   = dbl ? {DP_EXP_W{1'b1}} : DP_EXP_W'({SP_EXP_W{1'b1}});
    expZero  = (expField == '0);
    expOnes  = (expField == expMax);
    fracZero = (frac == '0);
    isZero   = expZero && fracZero;
    isSub    = expZero && !fracZero;
    isInf    = expOnes && fracZero;
    isNan    = expOnes && !fracZero;
  end

  // Leading-zero count: the highest set bit wins.
  always_comb begin
    lz = '0;
    for (int i = 0; i < DP_FRAC_W; i++)
      if (frac[i]) lz = LZ_W'(DP_FRAC_W - 1 - i);
  end

  always_comb begin
    normFrac = isSub ? DP_FRAC_W'(frac << ({1'b0, lz} + 1'b1)) : frac;
    romIdx   = {isSub ? lz[0] : expField[0], normFrac[DP_FRAC_W-1 -: ROM_AW-1]};
    expNum   = isSub ? (dbl ? DP_BASE : SP_BASE) + EXP_CALC_W'(lz)
                     : (dbl ? DP_BASE : SP_BASE) - EXP_CALC_W'(expField);
    expRes   = expNum >> 1;
  end

  rsqrt_rom #(.ADDR_W(ROM_AW), .DATA_W(ROM_DW)) uRom (
    .rdAddr(romIdx),
    .rdData(romVal)
  );

  always_comb begin
    nextInv = 1'b0;
    nextDz  = 1'b0;
    if (isNan) begin
      nextRes = dbl ? DP_QNAN : SP_QNAN;
      nextInv = !frac[DP_FRAC_W-1];
    end else if (isZero) begin
      nextRes = dbl ? {sign, {DP_EXP_W{1'b1}}, {DP_FRAC_W{1'b0}}}
                    : {32'b0, sign, {SP_EXP_W{1'b1}}, {SP_FRAC_W{1'b0}}};
      nextDz  = 1'b1;
    end else if (sign) begin
      nextRes = dbl ? DP_QNAN : SP_QNAN;
      nextInv = 1'b1;
    end else if (isInf) begin
      nextRes = '0;
    end else if (dbl) begin
      nextRes = {1'b0, expRes[DP_EXP_W-1:0], romVal, {(DP_FRAC_W-ROM_DW){1'b0}}};
    end else begin
      nextRes = {32'b0, 1'b0, expRes[SP_EXP_W-1:0], romVal, {(SP_FRAC_W-ROM_DW){1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result      <= '0;
      flagInvalid <= 1'b0;
      flagDivZero <= 1'b0;
    end else if (strobes.capture) begin
      result      <= nextRes;
      flagInvalid <= nextInv;
      flagDivZero <= nextDz;
    end
  end
endmodule

// File: rtl/rsqrt_est.sv
module rsqrt_est
  import rsqrt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inDouble,
  input  logic [WORD_W-1:0] inOperand,
  output logic              outValid,
  output logic [WORD_W-1:0] outResult,
  output logic              outInvalid,
  output logic              outDivZero
);
  strobes_t strobes;

  rsqrt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDouble(inDouble),
    .strobes(strobes), .outValid(outValid)
  );

  rsqrt_dp uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .operand(inOperand),
    .result(outResult), .flagInvalid(outInvalid), .flagDivZero(outDivZero)
  );
endmodule

// File: rtl/rsqrt_est_chk.sv
module rsqrt_est_chk (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic        inDouble,
  input logic [63:0] inOperand,
  input logic        outValid,
  input logic [63:0] outResult,
  input logic        outInvalid,
  input logic        outDivZero
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_drops_R1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_single_upper_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !inDouble) |=> (outResult[63:32] == 32'h0));
  assert_dbl_zero_inf_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inDouble && inOperand[62:0] == 63'h0) |=>
      (outDivZero && !outInvalid && outResult[62:0] == {11'h7FF, 52'h0}));
  assert_invalid_is_qnan_R7: assert property (@(posedge clk) disable iff (!rstN)
    outInvalid |-> (outResult == 64'h7FF8_0000_0000_0000 ||
                    outResult == 64'h0000_0000_7FC0_0000));
  assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(outInvalid && outDivZero));
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && $stable(outInvalid) && $stable(outDivZero)));
endmodule

bind rsqrt_est rsqrt_est_chk uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inDouble(inDouble),
  .inOperand(inOperand), .outValid(outValid), .outResult(outResult),
  .outInvalid(outInvalid), .outDivZero(outDivZero)
);

// File: tb/tb_rsqrt_est.sv
module tb_rsqrt_est;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inDouble = 1'b0;
  logic [63:0] inOperand = '0;
  logic        outValid;
  logic [63:0] outResult;
  logic        outInvalid, outDivZero;

  int nChecks = 0;
  int nErrors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rsqrt_est dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inDouble(inDouble),
    .inOperand(inOperand), .outValid(outValid), .outResult(outResult),
    .outInvalid(outInvalid), .outDivZero(outDivZero)
  );

  task automatic expect64(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements.
  function automatic void refCalc(input bit dbl, input logic [63:0] op,
                                  output logic [63:0] res, output bit inv,
                                  output bit dz, output string tag);
    int fw, ew, bias, e, p, m, k, y, tbl, newE;
    logic [63:0] fr, qnan;
    logic s;
    bit allOnes;
    fw   = dbl ? 52 : 23;
    ew   = dbl ? 11 : 8;
    bias = dbl ? 1023 : 127;
    s    = dbl ? op[63] : op[31];
    e    = dbl ? int'(op[62:52]) : int'(op[30:23]);
    fr   = op & ((64'd1 << fw) - 1);
    allOnes = (e == (1 << ew) - 1);
    qnan = dbl ? 64'h7FF8_0000_0000_0000 : 64'h7FC0_0000;
    inv = 0; dz = 0;
    if (allOnes && fr != 0) begin
      res = qnan; inv = !fr[fw-1]; tag = "R8";
    end else if (e == 0 && fr == 0) begin
      res = (64'(s) << (fw + ew)) | (64'((1 << ew) - 1) << fw); dz = 1; tag = "R6";
    end else if (s) begin
      res = qnan; inv = 1; tag = "R7";
    end else if (allOnes) begin
      res = 0; tag = "R9";
    end else begin
      tag = (e == 0) ? "R5" : "R4";
      if (e == 0) begin
        while (!fr[fw-1]) begin e--; fr = fr << 1; end
        fr = (fr << 1) & ((64'd1 << fw) - 1);
      end
      p    = e & 1;
      m    = int'((fr >> (fw - 6)) & 63);
      k    = p ? 1 : 2;
      y    = int'($floor(256.0 * $sqrt(128.0 / real'(k * (2 * m + 129)))));
      tbl  = y - 128;
      newE = (3 * bias - 1 - e) / 2;
      res  = (64'(newE) << fw) | (64'(tbl) << (fw - 7));
    end
  endfunction

  logic        pVal = 1'b0, pDbl = 1'b0;
  logic [63:0] pOp = '0;
  logic [63:0] lastRes = '0;
  bit          lastInv = 0, lastDz = 0;

  task automatic step(bit v, bit d, logic [63:0] op);
    logic [63:0] er;
    bit ei, ed;
    string tag;
    int fw;
    @(negedge clk);
    expect64("R1 outValid", 64'(outValid), 64'(pVal));
    if (pVal) begin
      refCalc(pDbl, pOp, er, ei, ed, tag);
      fw = pDbl ? 52 : 23;
      if (!pDbl) expect64("R2 upper half", {32'b0, outResult[63:32]}, 64'h0);
      if (tag == "R4" || tag == "R5") begin
        expect64("R3 fraction", outResult & ((64'd1 << fw) - 1), er & ((64'd1 << fw) - 1));
        expect64(tag, outResult >> fw, er >> fw);
        expect64("R11 flags", {62'b0, outInvalid, outDivZero}, 64'h0);
      end else begin
        expect64(tag, outResult, er);
        expect64({tag, " flags"}, {62'b0, outInvalid, outDivZero}, {62'b0, ei, ed});
      end
      lastRes = er; lastInv = ei; lastDz = ed;
    end else begin
      expect64("R10 hold", outResult, lastRes);
      expect64("R10 hold flags", {62'b0, outInvalid, outDivZero}, {62'b0, lastInv, lastDz});
    end
    inValid = v; inDouble = d; inOperand = op;
    pVal = v; pDbl = d; pOp = op;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect64("R1 reset outputs", {outResult[62:0], outValid}, 64'h0);
    expect64("R1 reset flags", {62'b0, outInvalid, outDivZero}, 64'h0);
    rstN = 1'b1;
    // Directed single precision
    step(1, 0, 64'h0000_0000_3F80_0000);  // 1.0 -> 0x3F7F0000
    step(1, 0, 64'hDEAD_BEEF_4080_0000);  // 4.0, upper bits ignored (R2)
    step(1, 0, 64'h0000_0000_0000_0000);  // +0
    step(1, 0, 64'h0000_0000_8000_0000);  // -0
    step(1, 0, 64'h0000_0000_7F80_0000);  // +inf
    step(1, 0, 64'h0000_0000_FF80_0000);  // -inf
    step(1, 0, 64'h0000_0000_7F80_0001);  // signaling NaN
    step(1, 0, 64'h0000_0000_7FC0_0001);  // quiet NaN
    step(1, 0, 64'h0000_0000_BF80_0000);  // -1.0
    step(1, 0, 64'h0000_0000_0000_0001);  // smallest subnormal
    step(1, 0, 64'h0000_0000_0040_0000);  // largest-power subnormal
    step(1, 0, 64'h0000_0000_7F7F_FFFF);  // largest normal
    step(0, 0, 64'h0000_0000_3F80_0000);  // idle: hold (R10)
    step(0, 1, 64'h0);
    // Directed double precision
    step(1, 1, 64'h3FF0_0000_0000_0000);
    step(1, 1, 64'h0000_0000_0000_0000);
    step(1, 1, 64'h8000_0000_0000_0000);
    step(1, 1, 64'h7FF0_0000_0000_0000);
    step(1, 1, 64'hFFF0_0000_0000_0000);
    step(1, 1, 64'h7FF0_0000_0000_0001);
    step(1, 1, 64'h7FF8_0000_0000_0000);
    step(1, 1, 64'h0000_0000_0000_0001);
    step(1, 1, 64'h0008_0000_0000_0000);
    step(1, 1, 64'h0010_0000_0000_0000);
    // Random stream with biased exponent fields and idle gaps
    for (int i = 0; i < 2000; i++) begin
      bit d;
      int sel;
      d   = $urandom_range(1, 0) == 1;
      r   = {$urandom, $urandom};
      sel = $urandom_range(9, 0);
      if (sel == 0) begin
        if (d) r[62:52] = '0; else r[30:23] = '0;
      end else if (sel == 1) begin
        if (d) r[62:52] = '1; else r[30:23] = '1;
      end else if (sel == 2) begin
        if (d) r[51:0] = 52'h1 << $urandom_range(51, 0);
        else   r[22:0] = 23'h1 << $urandom_range(22, 0);
        if (d) r[62:52] = '0; else r[30:23] = '0;
      end
      step($urandom_range(4, 0) != 0, d, r);
    end
    step(0, 0, 64'h0);
    step(0, 0, 64'h0);
    summary();
    $finish;
  end
endmodule